// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer

This block is a bus-mapped timer peripheral with six independent up-counting channels, numbered 1 to 6. Each channel has a control word, a clock-configuration word, a counter and a compare value. The control word selects one of three count modes: one-shot, repeat or free-run. A one-shot or repeat channel raises a pending flag when its counter reaches the compare value. A free-run channel counts without end and serves as a monotonic time base. The channels share an interrupt-enable register and an interrupt-acknowledge register, each with one bit per channel. A single interrupt line is the OR of the pending flags whose enable bits are set.

Software uses the block through a single-cycle synchronous register port. A write completes on the clock edge where `bus_we` is high. Read data depends combinationally on `bus_addr`. Each channel counts either on every bus clock or on a slow time-base tick. The slow tick is a one-cycle enable pulse synchronous to the bus clock. Either source can be divided by two.

Each channel is controlled by a small state machine with four states. CH_STOP is the idle state, where the counter holds. CH_ONCE is a one-shot run, CH_LOOP is a repeat run and CH_FREE is a free run. The transitions are as follows:
- Start: a control write with the enable bit set moves CH_STOP (or any other state) to CH_ONCE for mode 0, to CH_FREE for mode 3, and to CH_LOOP for modes 1 and 2.
- Stop: a control write with the enable bit clear moves any state to CH_STOP.
- Expire: a compare match in CH_ONCE moves the channel to CH_STOP.
- CH_LOOP and CH_FREE stay where they are on every count.

Top module: `multi_timer`

## Requirements
- R1: After reset every register reads 0, every counter is 0, every channel is stopped and `irq` is low.
- R2: Register map, with n the channel number from 1 to 6:
  - Offset 0x00 is interrupt enable, with bit n-1 for channel n.
  - Offset 0x08 is the acknowledge/pending register.
  - Offset 0x10*n is control: bit 0 enables the channel, bit 1 clears the counter, and bits [5:4] hold the mode.
  - Offset 0x10*n+4 is clock configuration: bit 4 is the source and bit 0 is the divider.
  - Offset 0x10*n+8 is the counter and offset 0x10*n+0xC is the compare value.
  - Any other offset reads 0. Clock-configuration bits other than 4 and 0 read back as 0.
- R3: A running channel adds one to its counter on each qualified tick. A stopped channel holds its count. The edge of a control write never counts.
- R4: Clock bit 4 = 0 counts on every bus clock, and bit 4 = 1 counts on `slow_tick` pulses. Divider bit 0 = 1 counts on every second source pulse. A clock-configuration write restarts the divider phase.
- R5: In repeat mode (mode 1, or the spare code 2), a qualified tick while the counter equals the compare value sets the channel's pending flag and reloads the counter to 0. The period is compare+1 ticks.
- R6: In one-shot mode (mode 0), the match sets the pending flag, clears the enable bit (the channel goes to CH_STOP) and holds the count.
- R7: In free-run mode (mode 3), the counter wraps from its all-ones value to 0 and never sets a pending flag.
- R8: A control write with bit 1 set zeroes the counter and the divider phase on that edge. Bit 1 always reads back as 0.
- R9: A pending flag is set whatever the interrupt enable says. `irq` is high exactly when some channel has both its pending flag and its enable bit set.
- R10: Writing 1 to bit n-1 of offset 0x08 clears channel n's pending flag, and writing 0x3f clears them all. Reads of 0x08 return the pending flags. If a match and an acknowledge of the same channel fall on the same edge, the flag stays set.
- R11: A compare write takes effect from the next edge. A match on the write edge is judged against the old compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse of the slow time base |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt line |

## Verification
Two events can land on the same edge: a channel's compare match, which sets its pending flag, and a software acknowledge of that same flag. The bench runs a channel in repeat mode with a short period and writes the acknowledge register for that channel on every cycle of a window. This places several acknowledges exactly on match edges. A behavioural model, in which the set wins, predicts the pending register and `irq` every clock, and each cycle is judged against it. A second coincidence, a compare write on an edge where the counter is still being compared against the old value, is driven on channel 6 and judged the same way.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
    typedef enum logic [1:0] {
        CH_STOP = 2'd0,
        CH_ONCE = 2'd1,
        CH_LOOP = 2'd2,
        CH_FREE = 2'd3
    } ch_state_e;

    localparam logic [1:0] MODE_ONCE = 2'd0;
    localparam logic [1:0] MODE_FREE = 2'd3;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_CLR_BIT  = 1;
    localparam int CTL_MODE_LSB = 4;
    localparam int CFG_DIV_BIT  = 0;
    localparam int CFG_SRC_BIT  = 4;

    localparam int OFS_IEN    = 'h00;
    localparam int OFS_ACK    = 'h08;
    localparam int CH_STRIDE  = 'h10;
    localparam int OFS_CTRL   = 'h0;
    localparam int OFS_CFG    = 'h4;
    localparam int OFS_COUNT  = 'h8;
    localparam int OFS_CMP    = 'hC;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic use_slow,
    input  logic halve,
    input  logic slow_tick,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic phase_q;
    logic src_pulse;

    always_comb begin
        src_pulse = use_slow ? slow_tick : 1'b1;
        tick      = run & src_pulse & (~halve | phase_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (restart)
            phase_q <= 1'b0;
        else if (run && src_pulse && halve)
            phase_q <= ~phase_q;
    end
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             wr_ctrl,
    input  logic             wr_cfg,
    input  logic             wr_cmp,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [31:0]      ctrl_rd,
    output logic [31:0]      cfg_rd,
    output logic             hit_o
);
    ch_state_e        state_q, state_d;
    logic [1:0]       mode_q;
    logic             use_slow_q, halve_q;
    logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q;
    logic             tick, match, running, restart, hit;

    assign running = (state_q != CH_STOP);
    assign restart = wr_cfg | (wr_ctrl & wdata[CTL_CLR_BIT]);
    assign match   = (cnt_q == cmp_q);

    mtmr_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_slow (use_slow_q),
        .halve    (halve_q),
        .slow_tick(slow_tick),
        .run      (running),
        .restart  (restart),
        .tick     (tick)
    );

    // next state and match event
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        if (wr_ctrl) begin
            if (!wdata[CTL_EN_BIT]) begin
                state_d = CH_STOP;
            end else begin
                unique case (wdata[CTL_MODE_LSB +: 2])
                    MODE_ONCE: state_d = CH_ONCE;
                    MODE_FREE: state_d = CH_FREE;
                    default:   state_d = CH_LOOP;
                endcase
            end
        end else if (tick) begin
            unique case (state_q)
                CH_ONCE: if (match) begin
                    state_d = CH_STOP;
                    hit     = 1'b1;
                end
                CH_LOOP: if (match) hit = 1'b1;
                CH_FREE: ;
                CH_STOP: ;
            endcase
        end
    end

    // counter datapath
    always_comb begin
        cnt_d = cnt_q;
        if (wr_ctrl) begin
            if (wdata[CTL_CLR_BIT]) cnt_d = '0;
        end else if (tick) begin
            if (hit)
                cnt_d = (state_q == CH_LOOP) ? '0 : cnt_q;
            else
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cmp_q      <= '0;
            mode_q     <= 2'd0;
            use_slow_q <= 1'b0;
            halve_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_ctrl) mode_q <= wdata[CTL_MODE_LSB +: 2];
            if (wr_cmp)  cmp_q  <= wdata[CNT_W-1:0];
            if (wr_cfg) begin
                use_slow_q <= wdata[CFG_SRC_BIT];
                halve_q    <= wdata[CFG_DIV_BIT];
            end
        end
    end

    // outputs
    always_comb begin
        ctrl_rd                      = '0;
        ctrl_rd[CTL_EN_BIT]          = running;
        ctrl_rd[CTL_MODE_LSB +: 2]   = mode_q;
        cfg_rd                       = '0;
        cfg_rd[CFG_SRC_BIT]          = use_slow_q;
        cfg_rd[CFG_DIV_BIT]          = halve_q;
        cnt_o                        = cnt_q;
        cmp_o                        = cmp_q;
        hit_o                        = hit;
    end
endmodule

// File: rtl/multi_timer.sv
module multi_timer
    import mtmr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [NUM_CH-1:0]            ien_q, pend_q, ack_mask, ch_hit;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_cmp;
    logic [NUM_CH-1:0][31:0]      ch_ctrl, ch_cfg;
    logic                         wr_ien, wr_ack;

    assign wr_ien   = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
    assign wr_ack   = bus_we && (bus_addr == ADDR_W'(OFS_ACK));
    assign ack_mask = wr_ack ? bus_wdata[NUM_CH-1:0] : '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = CH_STRIDE * (i + 1);
        mtmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .slow_tick(slow_tick),
            .wr_ctrl  (bus_we && (bus_addr == ADDR_W'(BASE + OFS_CTRL))),
            .wr_cfg   (bus_we && (bus_addr == ADDR_W'(BASE + OFS_CFG))),
            .wr_cmp   (bus_we && (bus_addr == ADDR_W'(BASE + OFS_CMP))),
            .wdata    (bus_wdata),
            .cnt_o    (ch_cnt[i]),
            .cmp_o    (ch_cmp[i]),
            .ctrl_rd  (ch_ctrl[i]),
            .cfg_rd   (ch_cfg[i]),
            .hit_o    (ch_hit[i])
        );
    end

    // a match on the acknowledge edge keeps the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_mask) | ch_hit;
            if (wr_ien) ien_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_IEN)) bus_rdata[NUM_CH-1:0] = ien_q;
        if (bus_addr == ADDR_W'(OFS_ACK)) bus_rdata[NUM_CH-1:0] = pend_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_CTRL))  bus_rdata = ch_ctrl[i];
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_CFG))   bus_rdata = ch_cfg[i];
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_COUNT)) bus_rdata = 32'(ch_cnt[i]);
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_CMP))   bus_rdata = 32'(ch_cmp[i]);
        end
    end

    assign irq = |(pend_q & ien_q);
endmodule

// File: rtl/multi_timer_chk.sv
module multi_timer_chk #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_we,
    input logic [31:0]                  bus_wdata,
    input logic                         irq,
    input logic [NUM_CH-1:0]            ien_q,
    input logic [NUM_CH-1:0]            pend_q,
    input logic [NUM_CH-1:0]            ch_hit,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][31:0]      ch_ctrl
);
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8)) |=> ((pend_q & $past(bus_wdata[NUM_CH-1:0] & ~ch_hit)) == '0)); // R10
    AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_hit) |=> ((pend_q & $past(ch_hit)) == $past(ch_hit))); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R9

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam int BASE = 16 * (i + 1);
        AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(BASE) && bus_wdata[1]) |=> (ch_cnt[i] == '0)); // R8
        AST_FREE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[i][0] && ch_ctrl[i][5:4] == 2'd3) |-> !ch_hit[i]); // R7
        AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[i] && ch_ctrl[i][5:4] == 2'd0) |=> !ch_ctrl[i][0]); // R6
        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ctrl[i][0] && !(bus_we && bus_addr == ADDR_W'(BASE))) |=> $stable(ch_cnt[i])); // R3
    end
endmodule

bind multi_timer multi_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/multi_timer_test.sv
`timescale 1ns/1ps
module multi_timer_test;
    localparam int CW   = 12;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    int m_cnt[6], m_cmp[6], m_mode[6];
    bit m_en[6], m_src[6], m_div[6], m_ph[6];
    int m_pend = 0, m_ien = 0;

    always #2 clk = ~clk;

    multi_timer #(.NUM_CH(6), .CNT_W(CW), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int model_read(input int a);
        int n, o;
        if (a == 0) return m_ien;
        if (a == 8) return m_pend;
        n = a >> 4;
        o = a & 15;
        if (n < 1 || n > 6) return 0;
        case (o)
            0:  return int'(m_en[n-1]) | (m_mode[n-1] << 4);
            4:  return (int'(m_src[n-1]) << 4) | int'(m_div[n-1]);
            8:  return m_cnt[n-1];
            12: return m_cmp[n-1];
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_cnt[i] = 0; m_cmp[i] = 0; m_mode[i] = 0;
            m_en[i] = 0; m_src[i] = 0; m_div[i] = 0; m_ph[i] = 0;
        end
        m_pend = 0; m_ien = 0;
    endtask

    task automatic model_step();
        int ackm = 0;
        int hitm = 0;
        if (bus_we && bus_addr == 8'h08) ackm = int'(bus_wdata[5:0]);
        for (int i = 0; i < 6; i++) begin
            int base = 16 * (i + 1);
            bit wctrl = bus_we && bus_addr == 8'(base);
            bit wcfg  = bus_we && bus_addr == 8'(base + 4);
            bit wcmp  = bus_we && bus_addr == 8'(base + 12);
            bit s     = m_src[i] ? slow_tick : 1'b1;
            bit tk    = 1'b0;
            if (m_en[i] && s) begin
                if (m_div[i]) begin
                    if (m_ph[i]) tk = 1'b1;
                    m_ph[i] = !m_ph[i];
                end else tk = 1'b1;
            end
            if (wcfg || (wctrl && bus_wdata[1])) m_ph[i] = 1'b0;
            if (wctrl) begin
                m_en[i] = bus_wdata[0];
                m_mode[i] = int'(bus_wdata[5:4]);
                if (bus_wdata[1]) m_cnt[i] = 0;
            end else if (tk) begin
                if (m_mode[i] != 3 && m_cnt[i] == m_cmp[i]) begin
                    hitm |= (1 << i);
                    if (m_mode[i] == 0) m_en[i] = 1'b0;
                    else m_cnt[i] = 0;
                end else m_cnt[i] = (m_cnt[i] + 1) & MASK;
            end
            if (wcfg) begin
                m_src[i] = bus_wdata[4];
                m_div[i] = bus_wdata[0];
            end
            if (wcmp) m_cmp[i] = int'(bus_wdata) & MASK;
        end
        m_pend = (m_pend & ~ackm) | hitm;
        if (bus_we && bus_addr == 8'h00) m_ien = int'(bus_wdata[5:0]);
    endtask

    task automatic compare_model();
        int exp_rd = model_read(int'(bus_addr));
        bit exp_irq = (m_pend & m_ien) != 0;
        checks++;
        if (bus_rdata !== 32'(exp_rd)) begin
            errors++;
            $display("FAIL %s addr %02h rdata actual %08h expected %08h", tag, bus_addr, bus_rdata, exp_rd);
        end
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp_irq);
        end
    endtask

    task automatic step(input logic [7:0] a, input bit we, input logic [31:0] d, input bit st);
        bus_addr = a; bus_we = we; bus_wdata = d; slow_tick = st;
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(a, 1'b1, d, 1'b0);
    endtask

    task automatic idle(input logic [7:0] a, input int n);
        for (int k = 0; k < n; k++) step(a, 1'b0, '0, 1'b0);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string t);
        step(a, 1'b0, '0, 1'b0);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %02h actual %08h expected %08h", t, a, bus_rdata, exp);
        end
    endtask

    task automatic expect_irq(input bit exp, input string t);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", t, irq, exp);
        end
    endtask

    initial begin
        model_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        tag = "R1";
        expect_rd(8'h00, 32'h0, "R1");
        expect_rd(8'h08, 32'h0, "R1");
        expect_rd(8'h10, 32'h0, "R1");
        expect_rd(8'h18, 32'h0, "R1");
        expect_irq(1'b0, "R1");

        // R2: decoding, unmapped offsets, field readback
        tag = "R2";
        expect_rd(8'h04, 32'h0, "R2");
        expect_rd(8'h0C, 32'h0, "R2");
        expect_rd(8'h70, 32'h0, "R2");
        expect_rd(8'hFF, 32'h0, "R2");
        wr(8'h14, 32'h13);
        expect_rd(8'h14, 32'h11, "R2");
        wr(8'h14, 32'h0);
        // R8: clear bit reads back 0
        tag = "R8";
        wr(8'h10, 32'h32);
        expect_rd(8'h10, 32'h30, "R8");
        wr(8'h10, 32'h0);

        // R3 and R5: repeat channel 1, compare 4
        tag = "R3";
        wr(8'h00, 32'h01);
        wr(8'h1C, 32'h4);
        wr(8'h10, 32'h13);
        expect_rd(8'h18, 32'h1, "R3");
        tag = "R5";
        idle(8'h18, 25);

        // R10: acknowledge on every edge, some coinciding with matches
        tag = "R10";
        for (int k = 0; k < 12; k++) step(8'h08, 1'b1, 32'h01, 1'b0);
        idle(8'h08, 3);
        tag = "R3";
        wr(8'h10, 32'h10);
        idle(8'h18, 5);
        tag = "R10";
        wr(8'h08, 32'h3f);
        expect_rd(8'h08, 32'h0, "R10");

        // R6 and R9: one-shot channel 2, compare 3, interrupt masked
        tag = "R6";
        wr(8'h2C, 32'h3);
        wr(8'h20, 32'h03);
        idle(8'h28, 8);
        expect_rd(8'h20, 32'h0, "R6");
        expect_rd(8'h28, 32'h3, "R6");
        expect_rd(8'h08, 32'h2, "R9");
        expect_irq(1'b0, "R9");
        tag = "R9";
        wr(8'h00, 32'h02);
        expect_irq(1'b1, "R9");
        wr(8'h08, 32'h02);
        expect_irq(1'b0, "R10");

        // R7: free-run channel 3 wraps and stays silent
        tag = "R7";
        wr(8'h00, 32'h3f);
        wr(8'h30, 32'h33);
        idle(8'h38, (1 << CW) + 100);
        expect_rd(8'h08, 32'h0, "R7");
        wr(8'h30, 32'h30);

        // R4: slow source divided by two, then fast source divided by two
        tag = "R4";
        wr(8'h4C, 32'hFFF);
        wr(8'h44, 32'h11);
        wr(8'h40, 32'h33);
        for (int k = 0; k < 30; k++) step(8'h48, 1'b0, '0, (k % 3) == 2);
        expect_rd(8'h48, 32'd5, "R4");
        wr(8'h44, 32'h01);
        idle(8'h48, 9);
        expect_rd(8'h48, 32'd10, "R4");
        wr(8'h40, 32'h30);

        // R5: spare mode code 2 repeats
        tag = "R5";
        wr(8'h5C, 32'h2);
        wr(8'h50, 32'h23);
        idle(8'h58, 12);
        wr(8'h50, 32'h20);
        wr(8'h08, 32'h3f);

        // R11: compare rewritten while running
        tag = "R11";
        wr(8'h6C, 32'd10);
        wr(8'h60, 32'h13);
        idle(8'h68, 2);
        wr(8'h6C, 32'd5);
        idle(8'h68, 2);
        expect_rd(8'h68, 32'h0, "R11");
        expect_rd(8'h08, 32'h20, "R11");
        idle(8'h68, 10);
        wr(8'h08, 32'h3f);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule